// File: doc/BRIEF.md
# Plug-and-Play Configuration Port with Key Unlock

This block is the configuration front end of a multi-function I/O controller. The host sees it as two adjacent byte ports. The lower port holds an index and the upper port moves data. The port pair stays closed until the host writes a four-byte key to the index port. The last key byte depends on a strap input that records which base address the pair is decoded at.

Once open, the index port selects one of 256 configuration registers. A global register chooses the logical device number, and the per-device registers then act on that device's bank. Each bank holds an enable bit, two 16-bit I/O base addresses and an interrupt number. The banks drive output ports that the logical devices downstream use as their settings. Each bank trims base addresses to the bits its device decodes. Writing a fixed value to a global control register closes the port again.

Top module: `pnp_cfg_port`

## Requirements
- R1: After reset the port is closed (`cfg_open` low), the selected device number is 0x00, and every bank output (enable, both bases, interrupt) is zero.
- R2: Writing 0x87, 0x01, 0x55 and then a fourth byte to the index port (`host_addr`=0) opens the port. The fourth byte is 0x55 when `strap_alt` is 0 and 0xAA when `strap_alt` is 1. `cfg_open` rises in the cycle after the fourth write.
- R3: A byte that does not match the expected key byte restarts detection, so the fourth byte of the other strap does not open the port. A mismatching byte equal to 0x87 counts as the first byte of a new attempt.
- R4: While the port is closed, writes to the data port (`host_addr`=1) change nothing, and a read of either port returns 0xFF.
- R5: While the port is open, an index-port write sets the index, an index-port read returns it, and a data-port access reaches the register named by the index. Global register 0x07 holds the logical device number and reads back the value written.
- R6: Writing 0x02 to global register 0x02 closes the port. Any other value written there leaves it open. Register 0x02 reads as 0x00.
- R7: Device numbers 0x01, 0x02, 0x04, 0x05, 0x06, 0x07 and 0x0A select banks 0 to 6 in that order. With any other device number, per-device writes are dropped and per-device reads return 0x00.
- R8: Bit 0 of register 0x30 is the enable bit of the selected device and drives its `dev_active` bit. The other bits of 0x30 read as 0.
- R9: Registers 0x60 and 0x61 are the high and low bytes of the first I/O base. Registers 0x62 and 0x63 are the high and low bytes of the second I/O base. Each one updates only its own byte.
- R10: Stored bases are ANDed with a per-bank mask. First base: 0x0FF8 for banks 0, 1, 5 and 6; 0x0FF0 for bank 2; 0x0FFF for bank 3; 0x0000 for bank 4. Second base: 0x0FF0 for bank 2, 0x0FFF for bank 3, 0x0FF8 for bank 5, and 0x0000 for all other banks.
- R11: Register 0x70 holds the 8-bit interrupt number of the selected device.
- R12: Reading any other register index while the port is open returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | 1 when the port pair sits at the alternate base |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, registered, valid the cycle after `host_rd` |
| cfg_open | output | 1 | Configuration mode is open |
| dev_active | output | 7 | Enable bit per bank |
| dev_io0 | output | 112 | First I/O base per bank, bank n at bits 16n+15:16n |
| dev_io1 | output | 112 | Second I/O base per bank, same packing |
| dev_irq | output | 56 | Interrupt number per bank, bank n at bits 8n+7:8n |

## Verification
The in-line assertions check these rules on every cycle: a closed port reads 0xFF, a closed port leaves the index and device number unchanged, the completed key opens the port, a stray 0x87 restarts the key, the relock write closes the port, bank contents change only when that bank is written, and stored bases never carry bits outside their mask. Some behaviour shows only in the bench's scenarios: the strap-dependent fourth byte, the device-number-to-bank mapping, byte-lane placement of the bases, each bank's mask, and the register values that survive a relock and disappear on a fresh reset.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

  localparam int BYTE_W  = 8;
  localparam int BASE_W  = 16;
  localparam int N_DEV   = 7;

  localparam logic [BYTE_W-1:0] KEY_B0     = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_B1     = 8'h01;
  localparam logic [BYTE_W-1:0] KEY_B2     = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_LAST_P = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_LAST_A = 8'hAA;

  localparam logic [BYTE_W-1:0] REG_CTRL   = 8'h02;
  localparam logic [BYTE_W-1:0] REG_LDN    = 8'h07;
  localparam logic [BYTE_W-1:0] REG_ACT    = 8'h30;
  localparam logic [BYTE_W-1:0] REG_B0_HI  = 8'h60;
  localparam logic [BYTE_W-1:0] REG_B0_LO  = 8'h61;
  localparam logic [BYTE_W-1:0] REG_B1_HI  = 8'h62;
  localparam logic [BYTE_W-1:0] REG_B1_LO  = 8'h63;
  localparam logic [BYTE_W-1:0] REG_IRQ    = 8'h70;
  localparam logic [BYTE_W-1:0] CLOSE_VAL  = 8'h02;

  typedef enum logic [2:0] {
    KS_IDLE, KS_GOT1, KS_GOT2, KS_GOT3, KS_OPEN
  } key_state_e;

  function automatic logic [BYTE_W-1:0] slot_ldn(input int s);
    case (s)
      0: return 8'h01;
      1: return 8'h02;
      2: return 8'h04;
      3: return 8'h05;
      4: return 8'h06;
      5: return 8'h07;
      default: return 8'h0A;
    endcase
  endfunction

  function automatic logic [BASE_W-1:0] slot_mask0(input int s);
    case (s)
      2: return 16'h0FF0;
      3: return 16'h0FFF;
      4: return 16'h0000;
      default: return 16'h0FF8;
    endcase
  endfunction

  function automatic logic [BASE_W-1:0] slot_mask1(input int s);
    case (s)
      2: return 16'h0FF0;
      3: return 16'h0FFF;
      5: return 16'h0FF8;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/pnp_key_unlock.sv
module pnp_key_unlock
  import pnp_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              relock,
  output logic              unlocked
);

  key_state_e        state_q, state_d;
  logic [BYTE_W-1:0] want;
  logic [BYTE_W-1:0] last_key;

  assign last_key = strap_alt ? KEY_LAST_A : KEY_LAST_P;
  assign unlocked = (state_q == KS_OPEN);

  always_comb begin
    case (state_q)
      KS_GOT1: want = KEY_B1;
      KS_GOT2: want = KEY_B2;
      KS_GOT3: want = last_key;
      default: want = KEY_B0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (state_q == KS_OPEN) begin
      if (relock) state_d = KS_IDLE;
    end else if (idx_wr) begin
      if (wdata == want) begin
        case (state_q)
          KS_IDLE: state_d = KS_GOT1;
          KS_GOT1: state_d = KS_GOT2;
          KS_GOT2: state_d = KS_GOT3;
          default: state_d = KS_OPEN;
        endcase
      end else if (wdata == KEY_B0) begin
        state_d = KS_GOT1;
      end else begin
        state_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  // R2: a matching fourth byte opens the port
  p_open_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_GOT3 && idx_wr && wdata == last_key) |=> unlocked);

  // R3: a stray 0x87 while closed always restarts at the first byte
  p_restart_on_b0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && idx_wr && wdata == KEY_B0) |=> (state_q == KS_GOT1));

  // R6: the close request shuts the port
  p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> !unlocked);

endmodule

// File: rtl/pnp_global_regs.sv
module pnp_global_regs
  import pnp_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlocked,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] index,
  output logic [BYTE_W-1:0] ldn,
  output logic              relock,
  output logic              dev_wr
);

  logic              idx_en, ldn_en, data_wr;
  logic [BYTE_W-1:0] index_d, ldn_d;

  assign data_wr = unlocked && host_wr && host_addr;
  assign idx_en  = unlocked && host_wr && !host_addr;
  assign ldn_en  = data_wr && (index == REG_LDN);
  assign relock  = data_wr && (index == REG_CTRL) && (wdata == CLOSE_VAL);
  assign dev_wr  = data_wr && (index != REG_LDN) && (index != REG_CTRL);

  always_comb begin
    index_d = idx_en ? wdata : index;
    ldn_d   = ldn_en ? wdata : ldn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index <= '0;
      ldn   <= '0;
    end else begin
      index <= index_d;
      ldn   <= ldn_d;
    end
  end

  // R4: nothing global moves while the port is closed
  p_closed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(index) && $stable(ldn)));

endmodule

// File: rtl/pnp_dev_bank.sv
module pnp_dev_bank
  import pnp_cfg_pkg::*;
#(
  parameter logic [BASE_W-1:0] MASK0 = 16'h0FF8,
  parameter logic [BASE_W-1:0] MASK1 = 16'h0FF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] index,
  input  logic [BYTE_W-1:0] wdata,
  output logic              active,
  output logic [BASE_W-1:0] io0,
  output logic [BASE_W-1:0] io1,
  output logic [BYTE_W-1:0] irq,
  output logic [BYTE_W-1:0] rd_byte
);

  logic              active_d;
  logic [BASE_W-1:0] io0_d, io1_d;
  logic [BYTE_W-1:0] irq_d;

  always_comb begin
    active_d = active;
    io0_d    = io0;
    io1_d    = io1;
    irq_d    = irq;
    if (wr_stb) begin
      case (index)
        REG_ACT:   active_d = wdata[0];
        REG_B0_HI: io0_d = {wdata, io0[BYTE_W-1:0]} & MASK0;
        REG_B0_LO: io0_d = {io0[BASE_W-1:BYTE_W], wdata} & MASK0;
        REG_B1_HI: io1_d = {wdata, io1[BYTE_W-1:0]} & MASK1;
        REG_B1_LO: io1_d = {io1[BASE_W-1:BYTE_W], wdata} & MASK1;
        REG_IRQ:   irq_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      io0    <= '0;
      io1    <= '0;
      irq    <= '0;
    end else begin
      active <= active_d;
      io0    <= io0_d;
      io1    <= io1_d;
      irq    <= irq_d;
    end
  end

  always_comb begin
    case (index)
      REG_ACT:   rd_byte = {{(BYTE_W-1){1'b0}}, active};
      REG_B0_HI: rd_byte = io0[BASE_W-1:BYTE_W];
      REG_B0_LO: rd_byte = io0[BYTE_W-1:0];
      REG_B1_HI: rd_byte = io1[BASE_W-1:BYTE_W];
      REG_B1_LO: rd_byte = io1[BYTE_W-1:0];
      REG_IRQ:   rd_byte = irq;
      default:   rd_byte = '0;
    endcase
  end

  // R10: no stored base carries a bit outside its mask
  p_base_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((io0 & ~MASK0) == '0) && ((io1 & ~MASK1) == '0));

  // R7: a bank that is not written keeps its contents
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(active) && $stable(io0) && $stable(io1) && $stable(irq)));

endmodule

// File: rtl/pnp_cfg_port.sv
module pnp_cfg_port
  import pnp_cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strap_alt,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic                     host_addr,
  input  logic [7:0]               host_wdata,
  output logic [7:0]               host_rdata,
  output logic                     cfg_open,
  output logic [N_DEV-1:0]         dev_active,
  output logic [N_DEV*BASE_W-1:0]  dev_io0,
  output logic [N_DEV*BASE_W-1:0]  dev_io1,
  output logic [N_DEV*BYTE_W-1:0]  dev_irq
);

  logic [1:0]        rst_sync;
  logic              rst_in_n;
  logic              unlocked, relock, dev_wr;
  logic [BYTE_W-1:0] index, ldn;
  logic [N_DEV-1:0]  dev_sel;
  logic [N_DEV-1:0][BYTE_W-1:0] bank_rd;
  logic [BYTE_W-1:0] bank_or, rdata_d;
  logic              rd_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_in_n = rst_sync[1];

  pnp_key_unlock u_key (
    .clk      (clk),
    .rst_n    (rst_in_n),
    .strap_alt(strap_alt),
    .idx_wr   (host_wr && !host_addr),
    .wdata    (host_wdata),
    .relock   (relock),
    .unlocked (unlocked)
  );

  pnp_global_regs u_glb (
    .clk      (clk),
    .rst_n    (rst_in_n),
    .unlocked (unlocked),
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .wdata    (host_wdata),
    .index    (index),
    .ldn      (ldn),
    .relock   (relock),
    .dev_wr   (dev_wr)
  );

  for (genvar s = 0; s < N_DEV; s++) begin : g_bank
    assign dev_sel[s] = (ldn == slot_ldn(s));
    pnp_dev_bank #(
      .MASK0(slot_mask0(s)),
      .MASK1(slot_mask1(s))
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_in_n),
      .wr_stb (dev_wr && dev_sel[s]),
      .index  (index),
      .wdata  (host_wdata),
      .active (dev_active[s]),
      .io0    (dev_io0[s*BASE_W +: BASE_W]),
      .io1    (dev_io1[s*BASE_W +: BASE_W]),
      .irq    (dev_irq[s*BYTE_W +: BYTE_W]),
      .rd_byte(bank_rd[s])
    );
  end

  assign cfg_open = unlocked;
  assign rd_en    = host_rd && !host_wr;

  always_comb begin
    bank_or = '0;
    for (int s = 0; s < N_DEV; s++) begin
      if (dev_sel[s]) bank_or = bank_or | bank_rd[s];
    end
    if (!unlocked)       rdata_d = 8'hFF;
    else if (!host_addr) rdata_d = index;
    else if (index == REG_LDN)  rdata_d = ldn;
    else if (index == REG_CTRL) rdata_d = '0;
    else                 rdata_d = bank_or;
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n)  host_rdata <= '0;
    else if (rd_en) host_rdata <= rdata_d;
  end

  // R4: a read while closed returns all ones
  p_closed_read_r4: assert property (@(posedge clk) disable iff (!rst_in_n)
    (rd_en && !unlocked) |=> (host_rdata == 8'hFF));

  // R7: at most one bank is ever selected
  p_one_bank_r7: assert property (@(posedge clk) disable iff (!rst_in_n)
    $onehot0(dev_sel));

endmodule

// File: tb/tb_pnp_cfg_port.sv
module tb_pnp_cfg_port;
  import pnp_cfg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_alt = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic cfg_open;
  logic [N_DEV-1:0] dev_active;
  logic [N_DEV*BASE_W-1:0] dev_io0, dev_io1;
  logic [N_DEV*BYTE_W-1:0] dev_irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pnp_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_open(cfg_open),
    .dev_active(dev_active), .dev_io0(dev_io0), .dev_io1(dev_io1), .dev_irq(dev_irq)
  );

  // entry: {is_read, port, wbyte, expected, requirement}
  localparam int NV = 64;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1,1'b1,8'h00,8'hFF,8'd4},  // R4 closed data read
    {1'b1,1'b0,8'h00,8'hFF,8'd4},  // R4 closed index read
    {1'b0,1'b0,8'h07,8'h00,8'd4},
    {1'b0,1'b1,8'h05,8'h00,8'd4},  // dropped while closed
    {1'b0,1'b0,8'h87,8'h00,8'd2},  // R2 key
    {1'b0,1'b0,8'h01,8'h00,8'd2},
    {1'b0,1'b0,8'h55,8'h00,8'd2},
    {1'b0,1'b0,8'h55,8'h00,8'd2},
    {1'b0,1'b0,8'h07,8'h00,8'd5},
    {1'b1,1'b1,8'h00,8'h00,8'd4},  // R4 earlier device write was dropped
    {1'b0,1'b1,8'h01,8'h00,8'd5},
    {1'b1,1'b0,8'h00,8'h07,8'd5},  // R5 index readback
    {1'b1,1'b1,8'h00,8'h01,8'd5},  // R5 device number readback
    {1'b0,1'b0,8'h30,8'h00,8'd8},
    {1'b0,1'b1,8'hFF,8'h00,8'd8},
    {1'b1,1'b1,8'h00,8'h01,8'd8},  // R8 only bit 0 kept
    {1'b0,1'b0,8'h60,8'h00,8'd9},
    {1'b0,1'b1,8'h12,8'h00,8'd9},
    {1'b0,1'b0,8'h61,8'h00,8'd9},
    {1'b0,1'b1,8'h3F,8'h00,8'd9},
    {1'b1,1'b1,8'h00,8'h38,8'd10}, // R10 0x0FF8 low byte
    {1'b0,1'b0,8'h60,8'h00,8'd9},
    {1'b1,1'b1,8'h00,8'h02,8'd9},  // R9 high byte kept
    {1'b0,1'b0,8'h70,8'h00,8'd11},
    {1'b0,1'b1,8'h04,8'h00,8'd11},
    {1'b1,1'b1,8'h00,8'h04,8'd11}, // R11
    {1'b0,1'b0,8'h62,8'h00,8'd10},
    {1'b0,1'b1,8'h12,8'h00,8'd10},
    {1'b1,1'b1,8'h00,8'h00,8'd10}, // R10 serial has no second base
    {1'b0,1'b0,8'h07,8'h00,8'd7},
    {1'b0,1'b1,8'h04,8'h00,8'd7},
    {1'b0,1'b0,8'h61,8'h00,8'd10},
    {1'b0,1'b1,8'h3F,8'h00,8'd10},
    {1'b1,1'b1,8'h00,8'h30,8'd10}, // R10 0x0FF0
    {1'b0,1'b0,8'h62,8'h00,8'd10},
    {1'b0,1'b1,8'hAB,8'h00,8'd10},
    {1'b1,1'b1,8'h00,8'h0B,8'd10}, // R10 second base 0x0FF0
    {1'b0,1'b0,8'h30,8'h00,8'd7},
    {1'b1,1'b1,8'h00,8'h00,8'd7},  // R7 separate bank
    {1'b0,1'b0,8'h07,8'h00,8'd7},
    {1'b0,1'b1,8'h03,8'h00,8'd7},
    {1'b0,1'b0,8'h30,8'h00,8'd7},
    {1'b0,1'b1,8'h01,8'h00,8'd7},
    {1'b1,1'b1,8'h00,8'h00,8'd7},  // R7 unmapped number reads zero
    {1'b0,1'b0,8'h07,8'h00,8'd7},
    {1'b0,1'b1,8'h01,8'h00,8'd7},
    {1'b0,1'b0,8'h30,8'h00,8'd7},
    {1'b1,1'b1,8'h00,8'h01,8'd7},  // R7 bank 0 intact
    {1'b0,1'b0,8'h07,8'h00,8'd10},
    {1'b0,1'b1,8'h05,8'h00,8'd10},
    {1'b0,1'b0,8'h60,8'h00,8'd10},
    {1'b0,1'b1,8'hFF,8'h00,8'd10},
    {1'b1,1'b1,8'h00,8'h0F,8'd10}, // R10 0x0FFF high
    {1'b0,1'b0,8'h61,8'h00,8'd10},
    {1'b0,1'b1,8'hFF,8'h00,8'd10},
    {1'b1,1'b1,8'h00,8'hFF,8'd10}, // R10 0x0FFF low
    {1'b0,1'b0,8'h55,8'h00,8'd12},
    {1'b1,1'b1,8'h00,8'h00,8'd12}, // R12 unused index
    {1'b0,1'b0,8'h02,8'h00,8'd6},
    {1'b0,1'b1,8'h01,8'h00,8'd6},
    {1'b1,1'b1,8'h00,8'h00,8'd6},  // R6 wrong value keeps it open
    {1'b1,1'b0,8'h00,8'h02,8'd6},
    {1'b0,1'b1,8'h02,8'h00,8'd6},
    {1'b1,1'b1,8'h00,8'hFF,8'd6}   // R6 closed again
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] b);
    @(negedge clk);
    host_wr = 1'b1; host_addr = port; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic port, output logic [7:0] b);
    @(negedge clk);
    host_rd = 1'b1; host_addr = port;
    @(negedge clk);
    host_rd = 1'b0;
    b = host_rdata;
  endtask

  task automatic key(input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] c, input logic [7:0] d);
    wr(1'b0, a); wr(1'b0, b); wr(1'b0, c); wr(1'b0, d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    do_reset();
    // R1 reset state
    check("R1 open", cfg_open, 0);
    check("R1 active", dev_active, 0);
    check("R1 io0", dev_io0, 0);
    check("R1 io1", dev_io1, 0);
    check("R1 irq", dev_irq, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25]) begin
        rd(VEC[i][24], r);
        check($sformatf("R%0d vec%0d", VEC[i][7:0], i), r, VEC[i][15:8]);
      end else begin
        wr(VEC[i][24], VEC[i][23:16]);
      end
    end

    // R8 R9 R10 R11 bank outputs after the table
    check("R8 dev_active", dev_active, 7'b0000001);
    check("R9 bank0 io0", dev_io0[0 +: 16], 16'h0238);
    check("R11 bank0 irq", dev_irq[0 +: 8], 8'h04);
    check("R10 bank0 io1", dev_io1[0 +: 16], 16'h0000);
    check("R10 bank2 io0", dev_io0[32 +: 16], 16'h0030);
    check("R10 bank2 io1", dev_io1[32 +: 16], 16'h0B00);
    check("R10 bank3 io0", dev_io0[48 +: 16], 16'h0FFF);
    check("R6 closed", cfg_open, 0);

    // R3 stray 0x87 restarts as first byte
    wr(1'b0, 8'h87); wr(1'b0, 8'h01);
    key(8'h87, 8'h01, 8'h55, 8'h55);
    check("R3 restart on 87", cfg_open, 1);
    wr(1'b0, 8'h02); wr(1'b1, 8'h02);
    check("R6 relock", cfg_open, 0);

    // R3 other strap's last byte does not open
    key(8'h87, 8'h01, 8'h55, 8'hAA);
    check("R3 wrong last byte", cfg_open, 0);
    // R3 wrong middle byte then full key
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h00);
    wr(1'b0, 8'h55);
    check("R3 partial key", cfg_open, 0);
    key(8'h87, 8'h01, 8'h55, 8'h55);
    check("R3 after garbage", cfg_open, 1);
    wr(1'b0, 8'h02); wr(1'b1, 8'h02);

    // R2 alternate strap
    strap_alt = 1'b1;
    key(8'h87, 8'h01, 8'h55, 8'h55);
    check("R2 alt rejects 55", cfg_open, 0);
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55);
    check("R2 not yet open", cfg_open, 0);
    wr(1'b0, 8'hAA);
    check("R2 alt accepts AA", cfg_open, 1);
    // R5 registers kept across relock
    wr(1'b0, 8'h07); rd(1'b1, r);
    check("R5 ldn kept", r, 8'h05);

    // R1 reset clears everything
    do_reset();
    check("R1 reset closes", cfg_open, 0);
    check("R1 reset active", dev_active, 0);
    check("R1 reset io0", dev_io0, 0);
    check("R1 reset irq", dev_irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule